// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Scheduler

This block brings an asynchronous DRAM out of power-up and keeps its contents alive. It starts counting when reset is released and lets the supply settle for a fixed time. It then issues a fixed number of warm-up RAS pulses with CAS held high. Once these are done it raises a ready flag and starts a periodic tick. The tick period is the retention window divided by the number of rows, rounded down to whole clock cycles, so the full row set is always covered before the deadline.

Each tick adds one to a small saturating backlog. While the backlog is non-zero and the block is idle, it raises a refresh request toward the access controller. When the controller grants with no row open, the block drives a CAS-before-RAS cycle on its own strobe outputs. CAS falls first, then RAS falls, and both return high together before a precharge gap. The DRAM's internal counter picks the row, so the block has no address output. Ticks that arrive while a row is held open pile up in the backlog. A full backlog raises an urgent flag so that the controller closes its page at the next access boundary.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset is released, `ras_n` and `cas_n` stay high and `init_done` stays low for exactly PWRUP_US*CLK_MHZ clock edges. The first warm-up RAS fall appears on the edge that completes this count.
- R2: After the wait, exactly INIT_CYCLES RAS pulses are issued with `cas_n` high. Each pulse is RAS_LOW cycles low followed by PRECHG cycles high. `init_done` rises on the edge that ends the last pulse's high time. After that, RAS never falls while `cas_n` is high.
- R3: The refresh tick period is floor(RETENTION_US*CLK_MHZ/ROWS) cycles. If every request is granted at once, successive refresh cycles start exactly one period apart.
- R4: A refresh cycle proceeds in this order. `cas_n` falls while `ras_n` is high. CAS_LEAD cycles later `ras_n` falls. After RAS_LOW more cycles both rise on the same edge. Both then stay high for PRECHG cycles.
- R5: `we_n` is always 1 and `dq_drive` is always 0.
- R6: Each tick increments `pend_cnt`, saturating at BACKLOG_MAX. `ref_req` is 1 exactly when the block is idle after init and `pend_cnt` is non-zero. The reset value of `pend_cnt` is 0.
- R7: An accepted grant starts a refresh cycle and decrements `pend_cnt` on the same edge. If a tick and an accepted grant share an edge, `pend_cnt` is unchanged.
- R8: `ref_urgent` is 1 exactly when `pend_cnt` equals BACKLOG_MAX.
- R9: `ref_gnt` is ignored, so no refresh cycle starts and `pend_cnt` is not decremented, when `row_open` is 1 or `pend_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_open | input | 1 | Access controller is holding a DRAM row open |
| ref_gnt | input | 1 | Access controller grants the strobes for one refresh |
| init_done | output | 1 | Power-up wait and warm-up pulses finished |
| ref_req | output | 1 | Refresh wanted |
| ref_urgent | output | 1 | Backlog full; the open row must be closed |
| pend_cnt | output | $clog2(BACKLOG_MAX+1) | Number of ticks not yet serviced |
| ras_n | output | 1 | Row strobe driven by this block (active low) |
| cas_n | output | 1 | Column strobe driven by this block (active low) |
| we_n | output | 1 | Write enable, held inactive |
| dq_drive | output | 1 | Data bus drive enable, held off |

## Verification
A tick and an accepted grant can land on the same clock edge. The backlog must then hold its value rather than lose either event. The bench first watches `pend_cnt` step from 0 to 1 to learn the tick phase. It then pulses `ref_gnt` so that the grant is sampled exactly one period later. The scoreboard expects the count seen at the refresh start to equal the count before the grant. All other grants are placed on edges that are known to carry no tick, so their expected value is the count minus one.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [2:0] {
    ST_WAIT,
    ST_INIT_LO,
    ST_INIT_HI,
    ST_IDLE,
    ST_CBR_CAS,
    ST_CBR_RAS,
    ST_CBR_PRE
  } seq_state_e;
endpackage

// File: rtl/rs_timer.sv
module rs_timer #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (en) begin
      if (cnt == CW'(LIMIT - 1)) cnt <= '0;
      else                       cnt <= cnt + 1'b1;
    end
  end

  assign tick = en && (cnt == CW'(LIMIT - 1));

  // R3
  timer_range_chk: assert property (@(posedge clk) disable iff (rst)
    (32'(cnt) < LIMIT));

  // R3
  timer_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt == '0));
endmodule

// File: rtl/rs_backlog.sv
module rs_backlog #(
  parameter int MAX = 8,
  localparam int PW = $clog2(MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          dec,
  output logic [PW-1:0] pend,
  output logic          pend_nz,
  output logic          urgent
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
    end else begin
      unique case ({inc, dec})
        2'b10:   if (pend != PW'(MAX)) pend <= pend + 1'b1;
        2'b01:   pend <= pend - 1'b1;
        default: pend <= pend;
      endcase
    end
  end

  assign pend_nz = (pend != '0);
  assign urgent  = (pend == PW'(MAX));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (32'(pend) <= MAX));

  // R6
  tick_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !dec && !urgent) |=> (pend == $past(pend) + 1'b1));

  // R7
  grant_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (dec && !inc) |=> (pend == $past(pend) - 1'b1));

  // R7
  merge_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dec && inc) |=> $stable(pend));
endmodule

// File: rtl/rs_seq.sv
module rs_seq
  import rs_pkg::*;
#(
  parameter int INIT_CYCLES = 8,
  parameter int RAS_LOW     = 3,
  parameter int PRECHG      = 2,
  parameter int CAS_LEAD    = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic pw_tick,
  input  logic gnt_ok,
  input  logic pend_nz,
  output logic wait_en,
  output logic accept,
  output logic ref_req,
  output logic init_done,
  output logic ras_n,
  output logic cas_n
);
  localparam int MAX_A = (RAS_LOW > PRECHG) ? RAS_LOW : PRECHG;
  localparam int MAXPH = (MAX_A > CAS_LEAD) ? MAX_A : CAS_LEAD;
  localparam int PHW   = $clog2(MAXPH + 1);
  localparam int ICW   = $clog2(INIT_CYCLES + 1);

  seq_state_e     st, nxt;
  logic [PHW-1:0] ph, ph_nxt;
  logic [ICW-1:0] ic, ic_nxt;

  assign wait_en = (st == ST_WAIT);
  assign ref_req = (st == ST_IDLE) && pend_nz;
  assign accept  = ref_req && gnt_ok;

  always_comb begin
    nxt    = st;
    ph_nxt = (ph == '0) ? ph : ph - 1'b1;
    ic_nxt = ic;
    unique case (st)
      ST_WAIT: begin
        if (pw_tick) begin
          nxt    = ST_INIT_LO;
          ph_nxt = PHW'(RAS_LOW - 1);
        end
      end
      ST_INIT_LO: begin
        if (ph == '0) begin
          nxt    = ST_INIT_HI;
          ph_nxt = PHW'(PRECHG - 1);
        end
      end
      ST_INIT_HI: begin
        if (ph == '0) begin
          if (ic == ICW'(INIT_CYCLES - 1)) begin
            nxt = ST_IDLE;
          end else begin
            nxt    = ST_INIT_LO;
            ic_nxt = ic + 1'b1;
            ph_nxt = PHW'(RAS_LOW - 1);
          end
        end
      end
      ST_IDLE: begin
        if (accept) begin
          nxt    = ST_CBR_CAS;
          ph_nxt = PHW'(CAS_LEAD - 1);
        end
      end
      ST_CBR_CAS: begin
        if (ph == '0) begin
          nxt    = ST_CBR_RAS;
          ph_nxt = PHW'(RAS_LOW - 1);
        end
      end
      ST_CBR_RAS: begin
        if (ph == '0) begin
          nxt    = ST_CBR_PRE;
          ph_nxt = PHW'(PRECHG - 1);
        end
      end
      ST_CBR_PRE: begin
        if (ph == '0) nxt = ST_IDLE;
      end
      default: nxt = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_WAIT;
      ph        <= '0;
      ic        <= '0;
      ras_n     <= 1'b1;
      cas_n     <= 1'b1;
      init_done <= 1'b0;
    end else begin
      st        <= nxt;
      ph        <= ph_nxt;
      ic        <= ic_nxt;
      ras_n     <= !((nxt == ST_INIT_LO) || (nxt == ST_CBR_RAS));
      cas_n     <= !((nxt == ST_CBR_CAS) || (nxt == ST_CBR_RAS));
      init_done <= init_done || (nxt == ST_IDLE);
    end
  end

  // R1
  ras_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT) |-> (ras_n && cas_n && !init_done));

  // R2
  init_cas_high_chk: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> cas_n);

  // R4
  cas_first_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(ras_n) && init_done) |-> $past(!cas_n));

  // R4
  joint_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cas_n) |-> $rose(ras_n));

  // R9
  idle_only_chk: assert property (@(posedge clk) disable iff (rst)
    accept |-> (st == ST_IDLE && pend_nz));
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int CLK_MHZ      = 100,
  parameter int PWRUP_US     = 200,
  parameter int RETENTION_US = 32000,
  parameter int ROWS         = 2048,
  parameter int INIT_CYCLES  = 8,
  parameter int BACKLOG_MAX  = 8,
  parameter int RAS_LOW      = 3,
  parameter int PRECHG       = 2,
  parameter int CAS_LEAD     = 1,
  localparam int PW          = $clog2(BACKLOG_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          row_open,
  input  logic          ref_gnt,
  output logic          init_done,
  output logic          ref_req,
  output logic          ref_urgent,
  output logic [PW-1:0] pend_cnt,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic          dq_drive
);
  localparam int PWRUP_CYC = PWRUP_US * CLK_MHZ;
  localparam int INTERVAL  = (RETENTION_US * CLK_MHZ) / ROWS;

  logic wait_en, pw_tick, ref_tick, accept, pend_nz, gnt_ok;

  assign gnt_ok   = ref_gnt && !row_open;
  assign we_n     = 1'b1;
  assign dq_drive = 1'b0;

  rs_timer #(.LIMIT(PWRUP_CYC)) u_pwrup (
    .clk(clk), .rst(rst), .en(wait_en), .tick(pw_tick)
  );

  rs_timer #(.LIMIT(INTERVAL)) u_interval (
    .clk(clk), .rst(rst), .en(init_done), .tick(ref_tick)
  );

  rs_backlog #(.MAX(BACKLOG_MAX)) u_backlog (
    .clk(clk), .rst(rst), .inc(ref_tick), .dec(accept),
    .pend(pend_cnt), .pend_nz(pend_nz), .urgent(ref_urgent)
  );

  rs_seq #(
    .INIT_CYCLES(INIT_CYCLES), .RAS_LOW(RAS_LOW),
    .PRECHG(PRECHG), .CAS_LEAD(CAS_LEAD)
  ) u_seq (
    .clk(clk), .rst(rst), .pw_tick(pw_tick), .gnt_ok(gnt_ok),
    .pend_nz(pend_nz), .wait_en(wait_en), .accept(accept),
    .ref_req(ref_req), .init_done(init_done),
    .ras_n(ras_n), .cas_n(cas_n)
  );

  // R9
  row_open_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_req && ref_gnt && row_open) |=> cas_n);

  // R8
  urgent_chk: assert property (@(posedge clk) disable iff (rst)
    ref_urgent |-> (32'(pend_cnt) == BACKLOG_MAX));
endmodule

// File: tb/dram_refresh_sched_test.sv
module dram_refresh_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_MHZ = 4, PWRUP_US = 200, RET_US = 32000, ROWS = 2048;
  localparam int INITC = 8, BMAX = 8, RL = 3, PRE = 2, CL = 1;
  localparam int PWR  = PWRUP_US * CLK_MHZ;
  localparam int INTV = (RET_US * CLK_MHZ) / ROWS;
  localparam int PW   = $clog2(BMAX + 1);

  logic clk = 0, rst = 1, row_open = 0, ref_gnt = 0;
  logic init_done, ref_req, ref_urgent, ras_n, cas_n, we_n, dq_drive;
  logic [PW-1:0] pend_cnt;

  dram_refresh_sched #(
    .CLK_MHZ(CLK_MHZ), .PWRUP_US(PWRUP_US), .RETENTION_US(RET_US), .ROWS(ROWS),
    .INIT_CYCLES(INITC), .BACKLOG_MAX(BMAX), .RAS_LOW(RL), .PRECHG(PRE), .CAS_LEAD(CL)
  ) uut (
    .clk(clk), .rst(rst), .row_open(row_open), .ref_gnt(ref_gnt),
    .init_done(init_done), .ref_req(ref_req), .ref_urgent(ref_urgent),
    .pend_cnt(pend_cnt), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .dq_drive(dq_drive)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int exp_q[$];
  int cbr_cnt = 0, init_pulses = 0, late_ras_only = 0, we_viol = 0;
  int cas_lo = 0, ras_lo = 0;
  bit prev_ras = 1, prev_cas = 1, auto_on = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // monitor: pops scoreboard items at each refresh start and checks strobe shape
  always @(negedge clk) begin
    if (!rst) begin
      if (!we_n || dq_drive) we_viol++;
      if (prev_ras && !ras_n && cas_n) begin
        if (!init_done) init_pulses++;
        else late_ras_only++;
      end
      if (prev_cas && !cas_n) begin
        cbr_cnt++;
        check(ras_n == 1'b1, "R4 ras high at cas fall", ras_n, 1);
        if (exp_q.size() == 0) check(0, "R7 unexpected refresh start", pend_cnt, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          check(int'(pend_cnt) == e, "R7 pending at refresh start", pend_cnt, e);
        end
        cas_lo = 0;
        ras_lo = 0;
      end
      if (!cas_n) cas_lo++;
      if (!cas_n && !ras_n) ras_lo++;
      if (!prev_cas && cas_n) begin
        check(!prev_ras && ras_n, "R4 joint release", ras_n, 1);
        check(cas_lo == CL + RL, "R4 cas low length", cas_lo, CL + RL);
        check(ras_lo == RL, "R4 ras low length", ras_lo, RL);
      end
      prev_ras = ras_n;
      prev_cas = cas_n;
    end
  end

  // driver for immediate-grant mode
  always @(negedge clk) begin
    if (auto_on) begin
      if (ref_gnt) ref_gnt = 0;
      else if (ref_req && !row_open) begin
        exp_q.push_back(int'(pend_cnt) - 1);
        ref_gnt = 1;
      end
    end
  end

  task automatic grant_pulse(input bit expect_cbr, input int exp_pend);
    if (expect_cbr) exp_q.push_back(exp_pend);
    ref_gnt = 1;
    @(negedge clk);
    ref_gnt = 0;
  endtask

  task automatic wait_cbr(output int at);
    int c;
    c = cbr_cnt;
    while (cbr_cnt == c) @(negedge clk);
    at = cyc;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog expired", cyc, 0);
    summary();
  end

  initial begin
    int rel, t, s0, s1, s2, s3, p, tref, c;
    repeat (4) @(negedge clk);
    check(!init_done && ras_n && cas_n && !ref_req, "R1 reset state strobes", {init_done, ras_n, cas_n}, 3'b011);
    check(pend_cnt == 0, "R6 reset pending", pend_cnt, 0);
    rst = 0;
    rel = cyc;
    while (ras_n) @(negedge clk);
    check(cyc - rel == PWR, "R1 first ras after wait", cyc - rel, PWR);
    while (!init_done) @(negedge clk);
    t = cyc - rel;
    check(t == PWR + INITC * (RL + PRE), "R2 init_done edge", t, PWR + INITC * (RL + PRE));
    check(init_pulses == INITC, "R2 warm-up pulse count", init_pulses, INITC);

    // R9: grant with empty backlog
    check(pend_cnt == 0 && !ref_req, "R6 idle with empty backlog", pend_cnt, 0);
    grant_pulse(0, 0);
    repeat (3) @(negedge clk);
    check(cbr_cnt == 0, "R9 grant ignored with zero pending", cbr_cnt, 0);

    // R3: immediate grants
    auto_on = 1;
    wait_cbr(s0); wait_cbr(s1); wait_cbr(s2); wait_cbr(s3);
    auto_on = 0;
    @(negedge clk);
    ref_gnt = 0;
    check(s1 - s0 == INTV, "R3 refresh spacing 1", s1 - s0, INTV);
    check(s2 - s1 == INTV, "R3 refresh spacing 2", s2 - s1, INTV);
    check(s3 - s2 == INTV, "R3 refresh spacing 3", s3 - s2, INTV);

    // R7: tick and grant on the same edge
    p = pend_cnt;
    while (pend_cnt == p) @(negedge clk);
    tref = cyc;
    check(pend_cnt == 1 && ref_req, "R6 tick raises pending", pend_cnt, 1);
    repeat (INTV - 1) @(negedge clk);
    p = pend_cnt;
    grant_pulse(1, p);
    repeat (10) @(negedge clk);

    // R6/R8: backlog while a row is held open
    row_open = 1;
    repeat (10 * INTV) @(negedge clk);
    check(pend_cnt == BMAX, "R6 backlog saturates", pend_cnt, BMAX);
    check(ref_urgent == 1'b1, "R8 urgent at full backlog", ref_urgent, 1);

    // R9: grant while row open
    c = cbr_cnt;
    grant_pulse(0, 0);
    repeat (4) @(negedge clk);
    check(cbr_cnt == c, "R9 grant ignored with row open", cbr_cnt, c);
    check(pend_cnt == BMAX, "R9 pending kept with row open", pend_cnt, BMAX);

    // R7/R8: grant on an edge without a tick
    row_open = 0;
    while (((cyc + 1 - tref) % INTV) == 0) @(negedge clk);
    grant_pulse(1, BMAX - 1);
    check(pend_cnt == BMAX - 1, "R7 grant decrements", pend_cnt, BMAX - 1);
    check(ref_urgent == 1'b0, "R8 urgent clears below full", ref_urgent, 0);
    repeat (10) @(negedge clk);

    check(we_viol == 0, "R5 we_n high and bus undriven", we_viol, 0);
    check(late_ras_only == 0, "R2 no ras-only pulse after init", late_ras_only, 0);
    check(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);
    summary();
  end
endmodule